// File: doc/BRIEF.md
# Display Row Fetch Engine

This block loads one character row of display data from an external word-wide memory into an on-chip row buffer. It shares the memory bus with a host processor. When asked to start a fill, it raises a bus request and waits a programmable warning interval, which gives the host time to finish its own access. It then runs a burst of read cycles on a multiplexed address/data bus and releases the bus when the burst is complete.

The row buffer has two halves. One half receives the words being fetched while the other half is read by the pixel pipeline through a registered read port. The roles of the two halves swap each time a fill completes, so a display row is never overwritten while it is being shown.

All sequencing advances on a clock enable that marks the roughly 6.04 MHz memory timebase. Each read cycle takes three enabled ticks, about 496 ns.

Top module: `dmf_fetch`

## Requirements
- R1: After a synchronous reset, `bus_req` is 0, `as_n`, `uds_n` and `lds_n` are 1, `ad_oe` is 0, `done` is 0, `fill_half` is 0 and `rw_rd` is 1.
- R2: A `start` seen on an enabled tick while idle raises `bus_req` on that tick. The first address phase (`ad_oe` rising) follows exactly 3·W enabled ticks later, where W = `warn_ticks` (0 to 127).
- R3: Each read cycle lasts three enabled ticks. In the first tick the address is driven with `as_n` high. In the second tick `as_n` is low and the address is still driven. In the third tick the bus is released and the data strobes are low. `as_n` therefore falls one tick before the data strobes, and `ad_in` is sampled at the end of the third tick.
- R4: `uds_n` and `lds_n` are always equal, so every access is a full 16-bit word. `rw_rd` stays 1 (read) at all times.
- R5: A fill performs exactly 2·COLS cycles. Cycle k drives the word address `base_addr + k`, wrapping modulo 2^16, with `base_addr` captured at start.
- R6: Words 2c and 2c+1 form column c of the row buffer. The even word goes to bits 31:16 and the odd word to bits 15:0.
- R7: The strobes rise at the end of the last cycle. On the next enabled tick `bus_req` falls and `done` pulses high for exactly one clock.
- R8: Fetched data goes into half `fill_half`. `fill_half` toggles with `done`. `disp_data` returns, one clock after `disp_col` is applied, the column held in the other half (the most recently completed row).
- R9: `start` has no effect while a fill is in progress. The burst keeps its addresses and length, and only one `done` is produced.
- R10: Bus outputs and the sequence state change only on ticks where `clk_en` is 1. The warning interval counts enabled ticks, not clocks.
- R11: `ad_oe` is never 1 while the data strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_en | input | 1 | Memory timebase tick enable |
| start | input | 1 | Request a row fill |
| base_addr | input | 16 | Word address of the first word of the row |
| warn_ticks | input | 7 | Warning interval in memory cycles (3 ticks each) |
| bus_req | output | 1 | Bus request to the host |
| as_n | output | 1 | Address strobe, active low |
| uds_n | output | 1 | Upper data strobe, active low |
| lds_n | output | 1 | Lower data strobe, active low |
| rw_rd | output | 1 | Read/write line, 1 = read |
| ad_out | output | 16 | Multiplexed bus, address value driven |
| ad_oe | output | 1 | Drive enable for `ad_out` |
| ad_in | input | 16 | Multiplexed bus, data returned by memory |
| fill_half | output | 1 | Row buffer half currently being filled |
| done | output | 1 | One-clock pulse when a row fill completes |
| disp_col | input | 6 | Column to read for display |
| disp_data | output | 32 | Column data from the display half |

## Verification
The hardest case to reach is the interaction of a stalling timebase with the warning counter and the bus phases. This case shows whether anything advances on clocks that carry no tick. The bench runs one fill with `clk_en` high only every third clock and measures the warning interval and the cycle spacing in enabled ticks. The swap of the buffer halves is reached by reading the display port in the middle of a second fill: the earlier row must still be visible there and must be replaced only after `done`. A second `start` is injected in the middle of a burst to show that it is ignored.

// File: rtl/dmf_pkg.sv
package dmf_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WARN = 2'd1,
    ST_BUS  = 2'd2,
    ST_DONE = 2'd3
  } fetch_state_e;

  typedef enum logic [1:0] {
    PH_ADDR = 2'd0,
    PH_HOLD = 2'd1,
    PH_DATA = 2'd2
  } bus_phase_e;

  localparam int TICKS_PER_CYCLE = 3;

endpackage

// File: rtl/dmf_warn_timer.sv
module dmf_warn_timer #(
  parameter int WARN_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              load,
  input  logic              run,
  input  logic [WARN_W-1:0] warn,
  output logic              last
);
  localparam int CNT_W = WARN_W + 2;

  logic [CNT_W-1:0] cnt_q;

  // warn * 3 without a multiplier: warn + 2*warn
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (tick) begin
      if (load) begin
        cnt_q <= {2'b00, warn} + {1'b0, warn, 1'b0};
      end else if (run && cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign last = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/dmf_bus_seq.sv
module dmf_bus_seq
  import dmf_pkg::*;
#(
  parameter int BUS_W  = 16,
  parameter int COLS   = 40,
  parameter int WARN_W = 7
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      tick,
  input  logic                      start,
  input  logic [BUS_W-1:0]          base,
  input  logic [WARN_W-1:0]         warn,
  input  logic [BUS_W-1:0]          ad_in,
  output logic                      bus_req,
  output logic                      as_n,
  output logic                      uds_n,
  output logic                      lds_n,
  output logic                      rw_rd,
  output logic [BUS_W-1:0]          ad_out,
  output logic                      ad_oe,
  output logic                      fill_half,
  output logic                      done,
  output logic                      wr_en,
  output logic [$clog2(COLS):0]     wr_addr,
  output logic [2*BUS_W-1:0]        wr_data
);
  localparam int COL_W  = $clog2(COLS);
  localparam int WORDS  = 2 * COLS;
  localparam int WORD_W = COL_W + 1;
  localparam logic [WORD_W-1:0] LAST_WORD = WORD_W'(WORDS - 1);

  fetch_state_e       state_q;
  bus_phase_e         phase_q;
  logic [WORD_W-1:0]  word_q;
  logic [BUS_W-1:0]   base_q;
  logic [BUS_W-1:0]   hi_q;
  logic               tmr_last;
  logic               tmr_load;

  assign tmr_load = (state_q == ST_IDLE) && start;

  dmf_warn_timer #(.WARN_W(WARN_W)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .tick (tick),
    .load (tmr_load),
    .run  (state_q == ST_WARN),
    .warn (warn),
    .last (tmr_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      phase_q   <= PH_ADDR;
      word_q    <= '0;
      base_q    <= '0;
      hi_q      <= '0;
      bus_req   <= 1'b0;
      as_n      <= 1'b1;
      uds_n     <= 1'b1;
      lds_n     <= 1'b1;
      rw_rd     <= 1'b1;
      ad_out    <= '0;
      ad_oe     <= 1'b0;
      fill_half <= 1'b0;
      done      <= 1'b0;
      wr_en     <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
    end else begin
      done  <= 1'b0;
      wr_en <= 1'b0;
      if (tick) begin
        unique case (state_q)
          ST_IDLE: begin
            if (start) begin
              bus_req <= 1'b1;
              base_q  <= base;
              word_q  <= '0;
              if (warn == '0) begin
                state_q <= ST_BUS;
                phase_q <= PH_ADDR;
                ad_oe   <= 1'b1;
                ad_out  <= base;
              end else begin
                state_q <= ST_WARN;
              end
            end
          end
          ST_WARN: begin
            if (tmr_last) begin
              state_q <= ST_BUS;
              phase_q <= PH_ADDR;
              ad_oe   <= 1'b1;
              ad_out  <= base_q;
            end
          end
          ST_BUS: begin
            unique case (phase_q)
              PH_ADDR: begin
                phase_q <= PH_HOLD;
                as_n    <= 1'b0;
              end
              PH_HOLD: begin
                phase_q <= PH_DATA;
                ad_oe   <= 1'b0;
                uds_n   <= 1'b0;
                lds_n   <= 1'b0;
              end
              default: begin
                uds_n <= 1'b1;
                lds_n <= 1'b1;
                as_n  <= 1'b1;
                if (!word_q[0]) begin
                  hi_q <= ad_in;
                end else begin
                  wr_en   <= 1'b1;
                  wr_addr <= {fill_half, word_q[WORD_W-1:1]};
                  wr_data <= {hi_q, ad_in};
                end
                if (word_q == LAST_WORD) begin
                  state_q <= ST_DONE;
                  phase_q <= PH_ADDR;
                end else begin
                  word_q  <= word_q + 1'b1;
                  phase_q <= PH_ADDR;
                  ad_oe   <= 1'b1;
                  ad_out  <= base_q + BUS_W'(word_q) + BUS_W'(1);
                end
              end
            endcase
          end
          default: begin
            bus_req   <= 1'b0;
            done      <= 1'b1;
            fill_half <= ~fill_half;
            state_q   <= ST_IDLE;
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/dmf_row_buf.sv
module dmf_row_buf #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    rd_data <= mem[rd_addr];
  end

endmodule

// File: rtl/dmf_fetch.sv
module dmf_fetch #(
  parameter int BUS_W  = 16,
  parameter int COLS   = 40,
  parameter int WARN_W = 7
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      clk_en,
  input  logic                      start,
  input  logic [BUS_W-1:0]          base_addr,
  input  logic [WARN_W-1:0]         warn_ticks,
  output logic                      bus_req,
  output logic                      as_n,
  output logic                      uds_n,
  output logic                      lds_n,
  output logic                      rw_rd,
  output logic [BUS_W-1:0]          ad_out,
  output logic                      ad_oe,
  input  logic [BUS_W-1:0]          ad_in,
  output logic                      fill_half,
  output logic                      done,
  input  logic [$clog2(COLS)-1:0]   disp_col,
  output logic [2*BUS_W-1:0]        disp_data
);
  localparam int COL_W = $clog2(COLS);
  localparam int BUF_AW = COL_W + 1;

  logic               wr_en;
  logic [BUF_AW-1:0]  wr_addr;
  logic [2*BUS_W-1:0] wr_data;
  logic [BUF_AW-1:0]  rd_addr;

  dmf_bus_seq #(.BUS_W(BUS_W), .COLS(COLS), .WARN_W(WARN_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .tick      (clk_en),
    .start     (start),
    .base      (base_addr),
    .warn      (warn_ticks),
    .ad_in     (ad_in),
    .bus_req   (bus_req),
    .as_n      (as_n),
    .uds_n     (uds_n),
    .lds_n     (lds_n),
    .rw_rd     (rw_rd),
    .ad_out    (ad_out),
    .ad_oe     (ad_oe),
    .fill_half (fill_half),
    .done      (done),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data)
  );

  assign rd_addr = {~fill_half, disp_col};

  dmf_row_buf #(.DATA_W(2*BUS_W), .ADDR_W(BUF_AW)) u_buf (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (disp_data)
  );

endmodule

// File: rtl/dmf_fetch_chk.sv
module dmf_fetch_chk #(
  parameter int BUS_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             clk_en,
  input logic             bus_req,
  input logic             as_n,
  input logic             uds_n,
  input logic             lds_n,
  input logic [BUS_W-1:0] ad_out,
  input logic             ad_oe,
  input logic             fill_half,
  input logic             done
);

  AST_STROBES_PAIRED: assert property (@(posedge clk) disable iff (rst)
    uds_n == lds_n); // R4

  AST_AS_LEADS_DS: assert property (@(posedge clk) disable iff (rst)
    $fell(uds_n) |-> (!as_n && $past(!as_n))); // R3

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
    $fell(as_n) |-> (ad_oe && $stable(ad_out))); // R3

  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (rst)
    !uds_n |-> !ad_oe); // R11

  AST_REQ_COVERS_DS: assert property (@(posedge clk) disable iff (rst)
    !uds_n |-> bus_req); // R7

  AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (rst)
    done |-> (!bus_req && uds_n && as_n)); // R7

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R7

  AST_HALF_SWAP: assert property (@(posedge clk) disable iff (rst)
    done |-> (fill_half != $past(fill_half))); // R8

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !clk_en |=> ($stable(bus_req) && $stable(as_n) && $stable(uds_n) && $stable(ad_oe))); // R10

endmodule

bind dmf_fetch dmf_fetch_chk #(.BUS_W(BUS_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .clk_en    (clk_en),
  .bus_req   (bus_req),
  .as_n      (as_n),
  .uds_n     (uds_n),
  .lds_n     (lds_n),
  .ad_out    (ad_out),
  .ad_oe     (ad_oe),
  .fill_half (fill_half),
  .done      (done)
);

// File: tb/dmf_fetch_bench.sv
module dmf_fetch_bench;
  localparam int COLS = 40;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        clk_en = 1'b1;
  logic        start = 1'b0;
  logic [15:0] base_addr = '0;
  logic [6:0]  warn_ticks = '0;
  logic        bus_req, as_n, uds_n, lds_n, rw_rd, ad_oe, fill_half, done;
  logic [15:0] ad_out, ad_in;
  logic [5:0]  disp_col = '0;
  logic [31:0] disp_data;

  always #2 clk = ~clk;

  dmf_fetch u_dmf_fetch (
    .clk(clk), .rst(rst), .clk_en(clk_en), .start(start),
    .base_addr(base_addr), .warn_ticks(warn_ticks),
    .bus_req(bus_req), .as_n(as_n), .uds_n(uds_n), .lds_n(lds_n),
    .rw_rd(rw_rd), .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in),
    .fill_half(fill_half), .done(done),
    .disp_col(disp_col), .disp_data(disp_data)
  );

  function automatic logic [15:0] memf(input logic [15:0] a);
    return (a * 16'h9E37) ^ 16'h5A3C;
  endfunction

  int checks = 0;
  int fails = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural memory and bus monitor
  logic [15:0] lat = '0;
  assign ad_in = (!uds_n && !lds_n) ? memf(lat) : 16'hDEAD;

  int div = 1;
  int divc = 0;
  int tickno = 0;
  bit req_prev = 0, uds_prev = 1, as_prev = 1;
  bit meas = 0;
  int wt = 0, wmeas = -1;
  int last_rise = 0, rel_gap = -1;
  int as_cnt = 0, addr_bad = 0, proto_bad = 0, cyc_bad = 0, last_as = 0;
  int done_cnt = 0;
  logic [15:0] exp_base = '0;

  always @(negedge clk) begin
    if (rst) begin
      clk_en = 1'b1;
      divc = 0;
    end else begin
      if (clk_en) begin
        tickno++;
        if (bus_req && !req_prev) begin meas = 1; wt = 0; end
        else if (meas) wt++;
        if (meas && ad_oe) begin wmeas = wt; meas = 0; end
        if (uds_n && !uds_prev) last_rise = tickno;
        if (!bus_req && req_prev) rel_gap = tickno - last_rise;
        if (!as_n && as_prev) begin
          lat = ad_out;
          if (ad_out !== exp_base + 16'(as_cnt)) addr_bad++;
          if (!uds_n || !ad_oe) proto_bad++;
          if (as_cnt > 0 && tickno - last_as != 3) cyc_bad++;
          last_as = tickno;
          as_cnt++;
        end
        req_prev = bus_req; uds_prev = uds_n; as_prev = as_n;
      end
      if (done) done_cnt++;
      if (!uds_n && ad_oe) proto_bad++;
      if (uds_n !== lds_n) proto_bad++;
      if (rw_rd !== 1'b1) proto_bad++;
      divc++;
      clk_en = (divc % div == 0);
    end
  end

  bit exp_half = 0;

  task automatic do_fill(input logic [15:0] base, input logic [6:0] w, input int dv,
                         input bit poke, input string tag);
    div = dv;
    exp_base = base; as_cnt = 0; addr_bad = 0; cyc_bad = 0;
    done_cnt = 0; wmeas = -1; rel_gap = -1;
    @(negedge clk);
    base_addr = base; warn_ticks = w; start = 1'b1;
    while (!bus_req) @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (40) @(negedge clk);
      base_addr = 16'h5555; warn_ticks = 7'd0; start = 1'b1;   // R9 stimulus
      repeat (12) @(negedge clk);
      start = 1'b0;
    end
    while (done_cnt == 0) @(negedge clk);
    repeat (4) @(negedge clk);
    exp_half = ~exp_half;
    chk(wmeas == 3 * int'(w), {"R2 warning ticks ", tag}, 64'(wmeas), 64'(3 * int'(w)));
    chk(as_cnt == 2 * COLS, {"R5 cycle count ", tag}, 64'(as_cnt), 64'(2 * COLS));
    chk(addr_bad == 0, {"R5 addresses ", tag}, 64'(addr_bad), 0);
    chk(cyc_bad == 0, {"R3 cycle spacing ", tag}, 64'(cyc_bad), 0);
    chk(rel_gap == 1, {"R7 release gap ", tag}, 64'(rel_gap), 1);
    chk(done_cnt == 1 && !bus_req, {"R7 single done ", tag}, 64'(done_cnt), 1);
    chk(fill_half == exp_half, {"R8 half toggled ", tag}, 64'(fill_half), 64'(exp_half));
  endtask

  task automatic check_buf(input logic [15:0] base, input string tag);
    int bad = 0;
    logic [31:0] first_act = '0, first_exp = '0;
    for (int c = 0; c < COLS; c++) begin
      logic [31:0] e;
      e = {memf(base + 16'(2 * c)), memf(base + 16'(2 * c + 1))};
      disp_col = 6'(c);
      @(negedge clk);
      if (disp_data !== e) begin
        if (bad == 0) begin first_act = disp_data; first_exp = e; end
        bad++;
      end
    end
    chk(bad == 0, {"R6 buffer contents ", tag}, 64'(first_act), 64'(first_exp));
  endtask

  task automatic test_reset();
    chk(bus_req == 0 && ad_oe == 0 && done == 0, "R1 reset req/oe/done", {bus_req, ad_oe, done}, 0);
    chk(as_n && uds_n && lds_n, "R1 reset strobes", {as_n, uds_n, lds_n}, 3'b111);
    chk(fill_half == 0, "R1 reset half", 64'(fill_half), 0);
    chk(rw_rd == 1, "R4 read line", 64'(rw_rd), 1);
  endtask

  task automatic test_swap();
    logic [31:0] olde;
    olde = {memf(16'h0100 + 16'd6), memf(16'h0100 + 16'd7)};
    div = 1;
    @(negedge clk);
    base_addr = 16'h2000; warn_ticks = 7'd2; start = 1'b1;
    exp_base = 16'h2000; as_cnt = 0; addr_bad = 0; cyc_bad = 0; done_cnt = 0;
    while (!bus_req) @(negedge clk);
    start = 1'b0;
    repeat (60) @(negedge clk);
    disp_col = 6'd3;
    @(negedge clk);
    chk(disp_data === olde, "R8 old row visible during fill", 64'(disp_data), 64'(olde));
    while (done_cnt == 0) @(negedge clk);
    repeat (4) @(negedge clk);
    exp_half = ~exp_half;
    chk(fill_half == exp_half, "R8 half toggled swap", 64'(fill_half), 64'(exp_half));
    check_buf(16'h2000, "swap");
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    test_reset();
    do_fill(16'h0100, 7'd1, 1, 0, "basic");
    check_buf(16'h0100, "basic");
    test_swap();
    do_fill(16'h0400, 7'd0, 1, 0, "warn0");
    check_buf(16'h0400, "warn0");
    do_fill(16'hFFC0, 7'd127, 1, 0, "warnmax-wrap");
    check_buf(16'hFFC0, "wrap");
    do_fill(16'h3000, 7'd3, 1, 1, "R9 busy start");
    check_buf(16'h3000, "R9 busy start");
    do_fill(16'h0800, 7'd2, 3, 0, "R10 slow enable");
    check_buf(16'h0800, "R10 slow enable");
    chk(proto_bad == 0, "R11 R3 R4 bus protocol", 64'(proto_bad), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule